// File: doc/BRIEF.md
# Dual-Row Configuration Store with Shadow

This block keeps the configuration word of a clock synthesizer and decides which stored copy drives the synthesizer datapath. It holds three copies of one 36-bit layout: a volatile shadow register that can be rewritten freely, and two write-once rows, each with its own valid bit. A single write port, with a 2-bit target and a strobe, loads any of the three copies. The selected copy is decoded into separate field outputs. The block also reports the loop ratio, 2*(P+5) over (Q+2), that those fields program.

The shadow serves while a frequency is being trimmed. Once the right value is found, it is committed to a row, and that row takes over. In normal mode the rows act as one programming plus one reprogramming. In frequency-select mode the two rows instead hold two alternative settings, and the `fsel` input picks between them. A strap can disable the shadow altogether. Reset stands for a fresh blank part: both rows, their valid bits and the shadow are cleared.

Top module: `cfg_store_top`

## Requirements
- R1: After reset all three copies and both valid bits are clear. `act_src` is 0 (shadow), every field output is 0 and `wr_err` is 0.
- R2: Field positions in `wr_data`, which are the same for every copy, are:
  - P in bits [11:0]
  - Q in [21:12]
  - divider code in [24:22]
  - divider source in [25]
  - tuning bits in [32:26]
  - duty level in [33]
  - power mode in [34]
  - timing mode in [35]

  The field outputs show the active copy.
- R3: Target 0 writes the shadow, any number of times. When the shadow is active, the new value appears on the outputs in the cycle after the write edge.
- R4: While `shadow_off` is 1, shadow writes are dropped and the shadow is never chosen. With no usable row, `act_src` is 3 and every field output is 0.
- R5: An accepted row write (target 1 = row 0, target 2 = row 1) stores the word and sets that row's valid bit. A valid row takes precedence over the shadow. `act_src` is 1 for row 0 and 2 for row 1.
- R6: In normal mode (`fs_mode`=0):
  - A row 1 write is accepted only once row 0 is valid and row 1 is blank.
  - A valid row 1 supersedes row 0.
  - A row 0 write is accepted only while row 0 is blank.
- R7: In frequency-select mode (`fs_mode`=1), `fsel`=0 selects row 0 and `fsel`=1 selects row 1, combinationally. If the selected row is blank, the shadow (or nothing, when the shadow is disabled) is used. Each row accepts exactly one write.
- R8: A rejected row write leaves all rows unchanged and raises `wr_err` for exactly the one cycle after the write edge.
- R9: `ratio_num` equals 2*(P+5) and `ratio_den` equals Q+2, computed from the active P and Q.
- R10: Target 3 is reserved. A write to it changes nothing and does not raise `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: 0 shadow, 1 row 0, 2 row 1, 3 reserved |
| wr_data | input | 36 | Configuration word to store |
| fsel | input | 1 | Row choice in frequency-select mode |
| shadow_off | input | 1 | Strap disabling the shadow |
| fs_mode | input | 1 | Strap: 0 reprogram-once, 1 frequency-select |
| fb_cnt | output | 12 | Active feedback count P |
| ref_cnt | output | 10 | Active reference count Q |
| div_code | output | 3 | Active post-divider code |
| div_src | output | 1 | Active divider source |
| tune | output | 7 | Active load tuning bits |
| duty_lvl | output | 1 | Active duty-level select |
| pwr_mode | output | 1 | Active power-down/output-enable select |
| sync_tim | output | 1 | Active synchronous/asynchronous select |
| act_src | output | 2 | Active copy: 0 shadow, 1 row 0, 2 row 1, 3 none |
| wr_err | output | 1 | Rejected row write, one-cycle pulse |
| ratio_num | output | 14 | 2*(P+5) |
| ratio_den | output | 11 | Q+2 |

## Verification
A write takes effect at the clock edge where the strobe is sampled. Both the stored word and the error pulse are therefore visible in the cycle that follows that edge and in no earlier one. `fsel` and the straps act on the selection without any register. The bench applies inputs on the falling edge and compares every output against its behavioural model a little after each falling edge. That point lies one full edge after any write and in the same cycle as any strap or select change. The directed checks are timed to that same point.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    localparam int FB_W   = 12;
    localparam int REF_W  = 10;
    localparam int DIV_W  = 3;
    localparam int TUNE_W = 7;
    localparam int NROWS  = 2;
    localparam int CFG_W  = FB_W + REF_W + DIV_W + 1 + TUNE_W + 3;
    localparam int NUM_W  = FB_W + 2;
    localparam int DEN_W  = REF_W + 1;

    // Most significant field first; fb_cnt sits at bit 0.
    typedef struct packed {
        logic              sync_tim;
        logic              pwr_mode;
        logic              duty_lvl;
        logic [TUNE_W-1:0] tune;
        logic              div_src;
        logic [DIV_W-1:0]  div_code;
        logic [REF_W-1:0]  ref_cnt;
        logic [FB_W-1:0]   fb_cnt;
    } cfg_word_t;

    typedef enum logic [1:0] {
        TGT_SHADOW = 2'd0,
        TGT_ROW0   = 2'd1,
        TGT_ROW1   = 2'd2,
        TGT_RSVD   = 2'd3
    } wr_tgt_e;

    typedef enum logic [1:0] {
        SRC_SHADOW = 2'd0,
        SRC_ROW0   = 2'd1,
        SRC_ROW1   = 2'd2,
        SRC_NONE   = 2'd3
    } act_src_e;

    function automatic logic [NUM_W-1:0] calc_num(input logic [FB_W-1:0] p);
        return (NUM_W'(p) + NUM_W'(5)) << 1;
    endfunction

    function automatic logic [DEN_W-1:0] calc_den(input logic [REF_W-1:0] q);
        return DEN_W'(q) + DEN_W'(2);
    endfunction

endpackage

// File: rtl/cfg_otp_row.sv
module cfg_otp_row
    import cfg_store_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cfg_word_t din,
    output cfg_word_t dout,
    output logic      valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (we && !valid) begin
            dout  <= din;
            valid <= 1'b1;
        end
    end

    // R5: once programmed, a row stays programmed
    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    // R8: a programmed row never changes its contents
    a_r8_row_locked: assert property (@(posedge clk) disable iff (rst)
        valid |=> $stable(dout));

endmodule

// File: rtl/cfg_write_arb.sv
module cfg_write_arb
    import cfg_store_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_tgt,
    input  logic             fs_mode,
    input  logic             shadow_off,
    input  logic [NROWS-1:0] row_valid,
    output logic             sh_we,
    output logic [NROWS-1:0] row_we,
    output logic             err_q
);

    logic [NROWS-1:0] row_ok;
    logic [NROWS-1:0] row_req;
    logic             reject;

    always_comb begin
        row_ok[0] = !row_valid[0];
        if (fs_mode)
            row_ok[1] = !row_valid[1];
        else
            row_ok[1] = row_valid[0] && !row_valid[1];
    end

    always_comb begin
        row_req[0] = wr_en && (wr_tgt == TGT_ROW0);
        row_req[1] = wr_en && (wr_tgt == TGT_ROW1);
        sh_we      = wr_en && (wr_tgt == TGT_SHADOW) && !shadow_off;
        row_we     = row_req & row_ok;
        reject     = |(row_req & ~row_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= reject;
    end

    // R6: after the single reprogram in normal mode, no row accepts a write
    a_r6_once_only: assert property (@(posedge clk) disable iff (rst)
        (!fs_mode && row_valid[1]) |-> (row_we == '0));

    // R6: row 1 cannot be taken before row 0 in normal mode
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        (!fs_mode && !row_valid[0]) |-> !row_we[1]);

    // R10: at most one copy is written per cycle
    a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sh_we, row_we}));

endmodule

// File: rtl/cfg_select.sv
module cfg_select
    import cfg_store_pkg::*;
(
    input  cfg_word_t        sh_word,
    input  cfg_word_t        row_word [NROWS],
    input  logic [NROWS-1:0] row_valid,
    input  logic             fs_mode,
    input  logic             fsel,
    input  logic             shadow_off,
    output cfg_word_t        act_word,
    output act_src_e         act_src
);

    act_src_e fallback;

    always_comb begin
        fallback = shadow_off ? SRC_NONE : SRC_SHADOW;
        if (fs_mode) begin
            if (fsel)
                act_src = row_valid[1] ? SRC_ROW1 : fallback;
            else
                act_src = row_valid[0] ? SRC_ROW0 : fallback;
        end else if (row_valid[1]) begin
            act_src = SRC_ROW1;
        end else if (row_valid[0]) begin
            act_src = SRC_ROW0;
        end else begin
            act_src = fallback;
        end
    end

    always_comb begin
        unique case (act_src)
            SRC_SHADOW: act_word = sh_word;
            SRC_ROW0:   act_word = row_word[0];
            SRC_ROW1:   act_word = row_word[1];
            default:    act_word = '0;
        endcase
    end

endmodule

// File: rtl/cfg_store_top.sv
module cfg_store_top
    import cfg_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_tgt,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              fsel,
    input  logic              shadow_off,
    input  logic              fs_mode,
    output logic [FB_W-1:0]   fb_cnt,
    output logic [REF_W-1:0]  ref_cnt,
    output logic [DIV_W-1:0]  div_code,
    output logic              div_src,
    output logic [TUNE_W-1:0] tune,
    output logic              duty_lvl,
    output logic              pwr_mode,
    output logic              sync_tim,
    output logic [1:0]        act_src,
    output logic              wr_err,
    output logic [NUM_W-1:0]  ratio_num,
    output logic [DEN_W-1:0]  ratio_den
);

    cfg_word_t        din;
    cfg_word_t        sh_word;
    cfg_word_t        row_word [NROWS];
    cfg_word_t        act_word;
    act_src_e         sel_src;
    logic [NROWS-1:0] row_valid;
    logic [NROWS-1:0] row_we;
    logic             sh_we;

    assign din = cfg_word_t'(wr_data);

    cfg_write_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_tgt     (wr_tgt),
        .fs_mode    (fs_mode),
        .shadow_off (shadow_off),
        .row_valid  (row_valid),
        .sh_we      (sh_we),
        .row_we     (row_we),
        .err_q      (wr_err)
    );

    always_ff @(posedge clk) begin
        if (rst)        sh_word <= '0;
        else if (sh_we) sh_word <= din;
    end

    for (genvar g = 0; g < NROWS; g++) begin : g_row
        cfg_otp_row u_row (
            .clk   (clk),
            .rst   (rst),
            .we    (row_we[g]),
            .din   (din),
            .dout  (row_word[g]),
            .valid (row_valid[g])
        );
    end

    cfg_select u_sel (
        .sh_word    (sh_word),
        .row_word   (row_word),
        .row_valid  (row_valid),
        .fs_mode    (fs_mode),
        .fsel       (fsel),
        .shadow_off (shadow_off),
        .act_word   (act_word),
        .act_src    (sel_src)
    );

    always_comb begin
        fb_cnt    = act_word.fb_cnt;
        ref_cnt   = act_word.ref_cnt;
        div_code  = act_word.div_code;
        div_src   = act_word.div_src;
        tune      = act_word.tune;
        duty_lvl  = act_word.duty_lvl;
        pwr_mode  = act_word.pwr_mode;
        sync_tim  = act_word.sync_tim;
        act_src   = sel_src;
        ratio_num = calc_num(act_word.fb_cnt);
        ratio_den = calc_den(act_word.ref_cnt);
    end

    // R4: a disabled shadow never becomes the active copy
    a_r4_shadow_never: assert property (@(posedge clk) disable iff (rst)
        shadow_off |-> (act_src != 2'd0));

    // R4: with the strap set, the shadow keeps its value through writes
    a_r4_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
        shadow_off |=> $stable(sh_word));

    // R8: the cycle flagged as a rejected write shows no row change
    a_r8_err_no_change: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> ($stable(row_valid) && $stable(row_word[0]) && $stable(row_word[1])));

endmodule

// File: tb/cfg_store_top_tb.sv
module cfg_store_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_tgt;
    logic [35:0] wr_data;
    logic        fsel;
    logic        shadow_off;
    logic        fs_mode;
    logic [11:0] fb_cnt;
    logic [9:0]  ref_cnt;
    logic [2:0]  div_code;
    logic        div_src;
    logic [6:0]  tune;
    logic        duty_lvl;
    logic        pwr_mode;
    logic        sync_tim;
    logic [1:0]  act_src;
    logic        wr_err;
    logic [13:0] ratio_num;
    logic [10:0] ratio_den;

    int n_checks = 0;
    int n_fails  = 0;

    // behavioural model state
    logic [35:0] m_sh;
    logic [35:0] m_row [2];
    bit          m_v   [2];
    bit          m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_store_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
        .fsel(fsel), .shadow_off(shadow_off), .fs_mode(fs_mode),
        .fb_cnt(fb_cnt), .ref_cnt(ref_cnt), .div_code(div_code), .div_src(div_src),
        .tune(tune), .duty_lvl(duty_lvl), .pwr_mode(pwr_mode), .sync_tim(sync_tim),
        .act_src(act_src), .wr_err(wr_err), .ratio_num(ratio_num), .ratio_den(ratio_den)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model update at each active edge
    always @(posedge clk) begin
        if (rst) begin
            m_sh = '0; m_row[0] = '0; m_row[1] = '0;
            m_v[0] = 0; m_v[1] = 0; m_err = 0;
        end else begin
            m_err = 0;
            if (wr_en) begin
                case (wr_tgt)
                    2'd0: if (!shadow_off) m_sh = wr_data;
                    2'd1: if (!m_v[0]) begin m_row[0] = wr_data; m_v[0] = 1; end
                          else m_err = 1;
                    2'd2: if (fs_mode ? !m_v[1] : (m_v[0] && !m_v[1])) begin
                              m_row[1] = wr_data; m_v[1] = 1;
                          end else m_err = 1;
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_src();
        int fb;
        fb = shadow_off ? 3 : 0;
        if (fs_mode) return m_v[fsel] ? (fsel ? 2 : 1) : fb;
        if (m_v[1]) return 2;
        if (m_v[0]) return 1;
        return fb;
    endfunction

    function automatic logic [35:0] exp_word();
        case (exp_src())
            0: return m_sh;
            1: return m_row[0];
            2: return m_row[1];
            default: return '0;
        endcase
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst === 1'b0) begin
            logic [35:0] w;
            w = exp_word();
            check("R5", "act_src",  act_src,  exp_src());
            check("R2", "fb_cnt",   fb_cnt,   w[11:0]);
            check("R2", "ref_cnt",  ref_cnt,  w[21:12]);
            check("R2", "div_code", div_code, w[24:22]);
            check("R2", "div_src",  div_src,  w[25]);
            check("R2", "tune",     tune,     w[32:26]);
            check("R2", "duty_lvl", duty_lvl, w[33]);
            check("R2", "pwr_mode", pwr_mode, w[34]);
            check("R2", "sync_tim", sync_tim, w[35]);
            check("R8", "wr_err",   wr_err,   m_err);
            check("R9", "ratio_num", ratio_num, 2 * (longint'(w[11:0]) + 5));
            check("R9", "ratio_den", ratio_den, longint'(w[21:12]) + 2);
        end
    end

    task automatic do_write(input logic [1:0] tgt, input logic [35:0] d);
        @(negedge clk);
        wr_en = 1; wr_tgt = tgt; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        #3;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        #3;
    endtask

    localparam logic [35:0] W_A = 36'h9_5A5_3C7_21;
    localparam logic [35:0] W_B = 36'h2_1F0_0AB_CD;
    localparam logic [35:0] W_C = 36'hF_0F0_F0F_0F;
    localparam logic [35:0] W_D = 36'h1_234_567_89;
    localparam logic [35:0] W_E = 36'h6_ABC_DEF_01;
    localparam logic [35:0] W_F = 36'h3_3FF_FFF_FF;

    initial begin
        rst = 1; wr_en = 0; wr_tgt = 0; wr_data = '0;
        fsel = 0; shadow_off = 0; fs_mode = 0;
        do_reset();
        // R1: reset state
        check("R1", "reset act_src", act_src, 0);
        check("R1", "reset fb_cnt", fb_cnt, 0);
        check("R1", "reset tune", tune, 0);
        check("R1", "reset wr_err", wr_err, 0);

        // R3: shadow rewritten twice, each visible after its edge
        do_write(2'd0, W_A);
        check("R3", "shadow A fb", fb_cnt, W_A[11:0]);
        check("R2", "shadow A tune", tune, W_A[32:26]);
        do_write(2'd0, W_B);
        check("R3", "shadow B ref", ref_cnt, W_B[21:12]);

        // R10: reserved target ignored, no error
        do_write(2'd3, W_C);
        check("R10", "rsvd no err", wr_err, 0);
        check("R10", "rsvd no change", fb_cnt, W_B[11:0]);

        // R6: row 1 before row 0 is rejected in normal mode
        do_write(2'd2, W_C);
        check("R6", "early row1 err", wr_err, 1);
        check("R6", "early row1 src", act_src, 0);

        // R5: row 0 programmed replaces shadow
        do_write(2'd1, W_C);
        check("R5", "row0 src", act_src, 1);
        check("R5", "row0 fb", fb_cnt, W_C[11:0]);
        do_write(2'd0, W_D);
        check("R3", "shadow hidden", fb_cnt, W_C[11:0]);

        // R8: rewrite of a valid row rejected, contents kept
        do_write(2'd1, W_E);
        check("R8", "row0 rewrite err", wr_err, 1);
        check("R8", "row0 kept", ref_cnt, W_C[21:12]);
        @(negedge clk); #3;
        check("R8", "err single cycle", wr_err, 0);

        // R6: single reprogram into row 1 supersedes row 0
        do_write(2'd2, W_E);
        check("R6", "row1 src", act_src, 2);
        check("R6", "row1 fb", fb_cnt, W_E[11:0]);
        do_write(2'd2, W_A);
        check("R6", "third program err", wr_err, 1);
        do_write(2'd1, W_A);
        check("R6", "row0 after reprogram err", wr_err, 1);
        check("R6", "row1 still active", fb_cnt, W_E[11:0]);

        // R7: frequency-select picks rows combinationally
        @(negedge clk); fs_mode = 1; fsel = 0; #3;
        check("R7", "fsel0 src", act_src, 1);
        check("R7", "fsel0 fb", fb_cnt, W_C[11:0]);
        @(negedge clk); fsel = 1; #3;
        check("R7", "fsel1 src", act_src, 2);

        // fresh part, frequency-select mode with only row 1 programmed
        do_reset();
        do_write(2'd2, W_F);
        check("R7", "fs row1 accept", wr_err, 0);
        @(negedge clk); fsel = 0; #3;
        check("R7", "fs blank row0 -> shadow", act_src, 0);
        @(negedge clk); fsel = 1; #3;
        check("R7", "fs row1 src", act_src, 2);
        // R9: extreme counts
        check("R9", "max num", ratio_num, 8200);
        check("R9", "max den", ratio_den, 1025);
        do_write(2'd2, W_A);
        check("R7", "fs row1 once", wr_err, 1);

        // R4: shadow disabled
        @(negedge clk); fsel = 0; shadow_off = 1; #3;
        check("R4", "none src", act_src, 3);
        check("R4", "none fb zero", fb_cnt, 0);
        do_write(2'd0, W_B);
        @(negedge clk); shadow_off = 0; #3;
        check("R4", "shadow write dropped", fb_cnt, 0);
        check("R4", "shadow back src", act_src, 0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule